// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This unit keeps the eight-bit status word of a serial EEPROM and decides, in the same cycle that a command is committed, whether a status write or an array write may begin. It takes single-cycle strobes from the instruction decoder: write-enable, write-disable, status-write commit and array-write commit. It also takes the data byte of a status write, the target address of an array write, the level of the active-low write-protect pin, and a one-cycle completion pulse from the self-timed write timer.

The unit returns the status byte for a status read. It also returns one accept flag per write kind and a live indication of the hardware-protected mode. The non-volatile protection bits are plain registers. They clear on reset and take new values only when an accepted status write completes. The serial shifter and the timer sit outside this unit.

Top module: `eeprom_status_guard`

## Requirements
- R1: The status byte is {SRWD, 0, 0, 0, BP1, BP0, WEL, WIP}, with bit 7 = SRWD, bits 3:2 = BP1:BP0, bit 1 = WEL and bit 0 = WIP. Bits 6:4 always read 0, and the whole byte is 8'h00 after reset.
- R2: A completed status write loads bits 7, 3 and 2 from its data byte. Data bits 6:4, 1 and 0 have no effect on the status byte.
- R3: WEL becomes 1 on the cycle after a write-enable strobe. WEL clears after a write-disable strobe or after a completion pulse. Completion takes priority over write-disable, and write-disable takes priority over write-enable when they coincide.
- R4: Status-write and array-write commits are rejected (accept flag low) when WEL is 0 or WIP is 1. This includes the cycle in which the completion pulse arrives.
- R5: The hardware-protected flag is high whenever SRWD is 1 and wp_n is low, whichever of the two came first. It drops as soon as wp_n goes high. While the flag is high, status writes are rejected.
- R6: The BP code selects the protected part of the array by the top two address bits. Code 00 protects nothing, 01 protects the top quarter (top bits 11), 10 protects the top half (top bit 1), and 11 protects the whole array. An array write to a protected address is rejected.
- R7: An accepted commit makes WIP read 1 from the next cycle. WIP stays 1 until the cycle after the completion pulse, then reads 0.
- R8: While a status write is in progress, SRWD and BP keep their old values. The new values appear together with WIP falling.
- R9: A rejected commit changes neither WEL nor WIP.
- R10: If both commit strobes arrive in the same cycle, only the status write can be accepted. The array write is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| wp_n | input | 1 | Write-protect pin level, low = protect |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write commit strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Array-write commit strobe |
| write_addr | input | AW | Target address of the array write |
| cycle_done | input | 1 | One-cycle pulse when the self-timed cycle ends |
| status | output | 8 | Status byte for status reads |
| wrsr_ok | output | 1 | Status-write commit accepted this cycle |
| write_ok | output | 1 | Array-write commit accepted this cycle |
| hw_protect | output | 1 | Hardware-protected mode is active |

## Verification
Completion of a running cycle and a fresh commit can land in the same clock. The same holds for a completion and a write-enable strobe. The bench forces both cases on purpose in directed steps, and it also reaches them often in a long pseudo-random phase. In the first case the commit must be rejected, because WIP still reads 1 in that cycle. In the second case WEL must end at 0. A behavioural reference model in the bench predicts every output on every cycle.

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic          cmd_write,
  input  logic [AW-1:0] write_addr,
  input  logic          cycle_done,
  output logic [7:0]    status,
  output logic          wrsr_ok,
  output logic          write_ok,
  output logic          hw_protect
);
  logic       srwd, wel, wip;
  logic [1:0] bp;
  logic       pend_sr, pend_srwd;
  logic [1:0] pend_bp;
  logic [1:0] top;
  logic       addr_locked;
  logic       finish;

  assign top = write_addr[AW-1:AW-2];

  always_comb begin
    case (bp)
      2'b00:   addr_locked = 1'b0;
      2'b01:   addr_locked = (top == 2'b11);
      2'b10:   addr_locked = top[1];
      default: addr_locked = 1'b1;
    endcase
  end

  assign hw_protect = srwd & ~wp_n;
  assign wrsr_ok    = cmd_wrsr & wel & ~wip & ~hw_protect;
  assign write_ok   = cmd_write & ~cmd_wrsr & wel & ~wip & ~addr_locked;
  assign finish     = wip & cycle_done;
  assign status     = {srwd, 3'b000, bp, wel, wip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd      <= 1'b0;
      bp        <= 2'b00;
      wel       <= 1'b0;
      wip       <= 1'b0;
      pend_sr   <= 1'b0;
      pend_srwd <= 1'b0;
      pend_bp   <= 2'b00;
    end else begin
      if (finish)        wel <= 1'b0;
      else if (cmd_wrdi) wel <= 1'b0;
      else if (cmd_wren) wel <= 1'b1;

      if (finish) begin
        wip <= 1'b0;
        if (pend_sr) begin
          srwd <= pend_srwd;
          bp   <= pend_bp;
        end
        pend_sr <= 1'b0;
      end else if (wrsr_ok) begin
        wip       <= 1'b1;
        pend_sr   <= 1'b1;
        pend_srwd <= wrsr_data[7];
        pend_bp   <= wrsr_data[3:2];
      end else if (write_ok) begin
        wip     <= 1'b1;
        pend_sr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_status_guard_chk.sv
module eeprom_status_guard_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_n,
  input logic          cmd_wren,
  input logic          cycle_done,
  input logic [7:0]    status,
  input logic          wrsr_ok,
  input logic          write_ok,
  input logic          hw_protect
);
  p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  p_wel_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cmd_wren));

  p_done_clears_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && cycle_done) |=> !status[1]);

  p_busy_rejects_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!wrsr_ok && !write_ok));

  p_hpm_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |-> (hw_protect && !wrsr_ok));

  p_accept_sets_wip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_ok || write_ok) |=> status[0]);

  p_bits_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !cycle_done) |=> $stable(status[7:2]));
endmodule

bind eeprom_status_guard eeprom_status_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren),
  .cycle_done(cycle_done), .status(status), .wrsr_ok(wrsr_ok),
  .write_ok(write_ok), .hw_protect(hw_protect)
);

// File: tb/eeprom_status_guard_test.sv
module eeprom_status_guard_test;
  localparam int AW = 11;
  localparam int SIZE = 1 << AW;

  logic clk = 0, rst_n = 0, wp_n = 1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cycle_done = 0;
  logic [7:0] wrsr_data = 0;
  logic [AW-1:0] write_addr = 0;
  logic [7:0] status;
  logic wrsr_ok, write_ok, hw_protect;

  int errors = 0, checks = 0;
  int m_srwd = 0, m_bp = 0, m_wel = 0, m_wip = 0;
  int p_sr = 0, p_srwd = 0, p_bp = 0;

  always #5 clk = ~clk;

  eeprom_status_guard #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .cycle_done(cycle_done), .status(status),
    .wrsr_ok(wrsr_ok), .write_ok(write_ok), .hw_protect(hw_protect));

  function automatic bit locked(int bpc, int a);
    if (bpc == 0) return 0;
    if (bpc == 1) return a >= (SIZE / 4) * 3;
    if (bpc == 2) return a >= SIZE / 2;
    return 1;
  endfunction

  function automatic bit e_hw();
    return m_srwd == 1 && wp_n == 0;
  endfunction
  function automatic bit e_wrsr();
    return cmd_wrsr && m_wel == 1 && m_wip == 0 && !e_hw();
  endfunction
  function automatic bit e_write();
    return cmd_write && !cmd_wrsr && m_wel == 1 && m_wip == 0 && !locked(m_bp, int'(write_addr));
  endfunction
  function automatic int e_status();
    return m_srwd * 128 + m_bp * 4 + m_wel * 2 + m_wip;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_srwd = 0; m_bp = 0; m_wel = 0; m_wip = 0; p_sr = 0;
    end else begin
      bit acc_sr, acc_wr;
      acc_sr = e_wrsr();
      acc_wr = e_write();
      if (m_wip == 1 && cycle_done) begin
        m_wip = 0; m_wel = 0;
        if (p_sr == 1) begin m_srwd = p_srwd; m_bp = p_bp; end
        p_sr = 0;
      end else begin
        if (cmd_wrdi) m_wel = 0;
        else if (cmd_wren) m_wel = 1;
        if (acc_sr) begin
          m_wip = 1; p_sr = 1; p_srwd = wrsr_data[7]; p_bp = wrsr_data[3:2];
        end else if (acc_wr) begin
          m_wip = 1; p_sr = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R1 status", int'(status), e_status());
    chk("R4 wrsr_ok", int'(wrsr_ok), int'(e_wrsr()));
    chk("R6 write_ok", int'(write_ok), int'(e_write()));
    chk("R5 hw_protect", int'(hw_protect), int'(e_hw()));
  end

  task automatic cyc(bit en, bit dis, bit sr, bit wr, bit dn, logic [7:0] d, int a);
    @(posedge clk); #1;
    cmd_wren = en; cmd_wrdi = dis; cmd_wrsr = sr; cmd_write = wr; cycle_done = dn;
    wrsr_data = d; write_addr = AW'(a);
    @(negedge clk); #1;
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    chk("R1 reset status", int'(status), 8'h00);
    cyc(0, 0, 0, 1, 0, 8'h00, 0);
    chk("R4 write without WEL", int'(write_ok), 0);
    idle();
    chk("R9 rejected leaves status", int'(status), 8'h00);
    cyc(1, 0, 0, 0, 0, 8'h00, 0); idle();
    chk("R3 wren sets WEL", int'(status), 8'h02);
    cyc(1, 1, 0, 0, 0, 8'h00, 0); idle();
    chk("R3 wrdi beats wren", int'(status), 8'h00);
    cyc(1, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 1, 0, 0, 8'hFF, 0);
    chk("R4 wrsr accepted", int'(wrsr_ok), 1);
    idle();
    chk("R8 old bits kept, R7 WIP set", int'(status), 8'h03);
    cyc(1, 0, 0, 0, 1, 8'h00, 0); idle();
    chk("R2 only bits 7,3,2 applied, R3 done beats wren", int'(status), 8'h8C);
    cyc(0, 0, 0, 0, 0, 8'h00, 0); wp_n = 0; #1;
    chk("R5 hpm entered by pin", int'(hw_protect), 1);
    cyc(1, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 1, 0, 0, 8'h00, 0);
    chk("R5 wrsr rejected in hpm", int'(wrsr_ok), 0);
    idle();
    chk("R9 WEL kept after reject", int'(status), 8'h8E);
    wp_n = 1; #1;
    chk("R5 pin high leaves hpm", int'(hw_protect), 0);
    cyc(0, 0, 1, 0, 0, 8'h04, 0);
    cyc(0, 0, 0, 0, 1, 8'h00, 0); idle();
    chk("R8 new bits at completion", int'(status), 8'h04);
    cyc(1, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 0, 1, 0, 8'h00, 'h600);
    chk("R6 top quarter locked", int'(write_ok), 0);
    cyc(0, 0, 0, 1, 0, 8'h00, 'h5FF);
    chk("R6 below quarter open", int'(write_ok), 1);
    cyc(0, 0, 0, 1, 0, 8'h00, 0);
    chk("R4 busy rejects", int'(write_ok), 0);
    cyc(0, 0, 0, 1, 1, 8'h00, 0);
    chk("R4 commit on done cycle rejected", int'(write_ok), 0);
    idle();
    chk("R7 WIP cleared", int'(status), 8'h04);
    cyc(1, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 1, 1, 0, 8'h08, 0);
    chk("R10 write loses to wrsr", int'(write_ok), 0);
    cyc(0, 0, 0, 0, 1, 8'h00, 0);
    cyc(1, 0, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 0, 1, 0, 8'h00, 'h400);
    chk("R6 upper half locked", int'(write_ok), 0);
    cyc(0, 0, 0, 1, 0, 8'h00, 'h3FF);
    chk("R6 lower half open", int'(write_ok), 1);
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      if ((r & 31) == 0) wp_n = ~wp_n;
      cyc(r[5:4] == 0, r[7:6] == 0 && r[8], r[10:9] == 0, r[12:11] == 0,
          r[14:13] == 0, r[23:16], int'(r[31:21]));
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule